// File: doc/BRIEF.md
# Port Change Detector

This block watches the upper pins of a general-purpose I/O port and reports when any of them differs from a snapshot taken at the most recent port access. Each watched pin takes part only when it is configured as an input and its own change-enable bit is set. A combinational wake line tells a sleep controller about a difference at once, with no clock needed. A sticky flag records the event, and an interrupt request passes the flag through a global enable.

Software clears the condition in two steps. It first reads or writes the port, which reloads the snapshot and ends the difference. It then clears the flag. A clear issued while a difference remains has no effect, because the flag is set again on the same edge. The snapshot is loaded only by a power-on reset and by port accesses, so it keeps its value through any other reset. A difference that is still present after such a reset sets the flag again.

Top module: `ioc_detect`

## Requirements
- R1: While `por_n` is low, the snapshot is loaded with the current watched pin values and `chg_flag` is cleared. After release, with the pins unchanged, `chg_flag` and `wake` are 0.
- R2: Port bits below bit 4 (bits 3:0 with the default widths) never affect `wake`, `chg_flag` or `chg_irq`.
- R3: A watched pin whose `dir_in` bit is 0 (output) is excluded from the comparison. A `dir_in` bit of 1 means input.
- R4: A watched pin whose `pin_en` bit is 0 is excluded. `pin_en[i]` controls port bit 4+i.
- R5: `wake` is high in the same cycle, with no clock edge, whenever any included watched pin differs from its snapshot bit.
- R6: On a clock edge where `wake` is high and neither `port_rd` nor `port_wr` is high, `chg_flag` becomes 1. It then stays 1 until a clear takes effect, even if the pins return to the snapshot value.
- R7: A `flag_clr` on an edge where `wake` is high and there is no port access leaves `chg_flag` at 1.
- R8: On an edge with `port_rd` or `port_wr` high, the snapshot takes the current pin values and no set occurs. A `flag_clr` on that same edge therefore clears `chg_flag`.
- R9: `chg_irq` is 1 exactly when `chg_flag` is 1 and `gie_en` is 1.
- R10: While `rst_n` is low, `chg_flag` is cleared but the snapshot holds. If a difference is present when `rst_n` returns high, `chg_flag` is set on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | Other system reset, active low, synchronous; the snapshot keeps its value |
| pin_in | input | 8 | Synchronized port pin values |
| dir_in | input | 8 | Direction per pin, 1 = input |
| pin_en | input | 4 | Change enable for each watched pin |
| gie_en | input | 1 | Global change-interrupt enable |
| port_rd | input | 1 | Port read strobe |
| port_wr | input | 1 | Port write strobe |
| flag_clr | input | 1 | Flag clear strobe |
| chg_flag | output | 1 | Sticky change flag |
| chg_irq | output | 1 | Interrupt request |
| wake | output | 1 | Unclocked wake request |

## Verification
An exhaustive sweep covers every combination of enable mask, watched-pin direction and toggle pattern against a fixed snapshot. This separates the three exclusion rules from one another and confirms that only the included toggles raise `wake` and the flag. Each combination continues with a clear during a persisting difference, then a port access combined with a clear, which shows that clearing is blocked or allowed as expected. Further sequences toggle only the low pins, revert pins after a set to show the flag is sticky, and apply the non-power-on reset during a difference to show that the snapshot survives and the flag comes back.

// File: rtl/ioc_detect.sv
module ioc_detect #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] dir_in,
  input  logic [N-1:0] pin_en,
  input  logic         gie_en,
  input  logic         port_rd,
  input  logic         port_wr,
  input  logic         flag_clr,
  output logic         chg_flag,
  output logic         chg_irq,
  output logic         wake
);
  localparam int LO = W - N;

  logic [N-1:0] snap;
  logic [N-1:0] live;
  logic         access;

  assign live     = pin_en & dir_in[W-1:LO] & (pin_in[W-1:LO] ^ snap);
  assign wake     = |live;
  assign access   = port_rd | port_wr;
  assign chg_irq  = chg_flag & gie_en;

  always_ff @(posedge clk) begin
    if (!por_n || access) snap <= pin_in[W-1:LO];
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) chg_flag <= 1'b0;
    else if (wake && !access) chg_flag <= 1'b1;
    else if (flag_clr) chg_flag <= 1'b0;
  end

  // R1
  por_clear_chk: assert property (@(posedge clk) !por_n |=> !chg_flag);
  // R6
  set_on_diff_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wake && !access) |=> (chg_flag || !rst_n || !por_n));
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (chg_flag && !flag_clr) |=> (chg_flag || !rst_n || !por_n));
  // R8
  snap_load_chk: assert property (@(posedge clk) disable iff (!por_n)
    access |=> (snap == $past(pin_in[W-1:LO])));
  // R10
  snap_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && !access && por_n) |=> $stable(snap));
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(chg_irq) |-> gie_en);
endmodule

// File: tb/ioc_detect_test.sv
module ioc_detect_test;
  logic       clk = 0;
  logic       por_n = 0, rst_n = 1;
  logic [7:0] pin_in = 8'hA5, dir_in = 8'hFF;
  logic [3:0] pin_en = 4'h0;
  logic       gie_en = 0, port_rd = 0, port_wr = 0, flag_clr = 0;
  logic       chg_flag, chg_irq, wake;

  int total = 0, bad = 0;
  logic [3:0] m_snap;
  logic       m_flag;

  always #2 clk = ~clk;

  ioc_detect uut (.*);

  task automatic chk(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(string tag, logic [7:0] p, logic [7:0] d, logic [3:0] e, logic g,
                      logic rd, logic wr, logic clr, logic pr, logic rs);
    logic mis;
    @(negedge clk);
    pin_in = p; dir_in = d; pin_en = e; gie_en = g;
    port_rd = rd; port_wr = wr; flag_clr = clr; por_n = pr; rst_n = rs;
    #1;
    mis = |(e & d[7:4] & (p[7:4] ^ m_snap));
    if (pr) chk({tag, "/R5 wake"}, wake, mis);
    @(posedge clk);
    if (!pr) begin m_snap = p[7:4]; m_flag = 0; end
    else begin
      if (!rs) m_flag = 0;
      else m_flag = (mis & !(rd | wr)) | (m_flag & !clr);
      if (rd | wr) m_snap = p[7:4];
    end
    #1;
    chk({tag, " flag"}, chg_flag, m_flag);
    chk({tag, "/R9 irq"}, chg_irq, m_flag & g);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_snap = 4'hA; m_flag = 0;
    // R1
    step("R1", 8'hA5, 8'hFF, 4'hF, 1, 0, 0, 0, 0, 1);
    step("R1", 8'hA5, 8'hFF, 4'hF, 1, 0, 0, 0, 1, 1);
    chk("R1 wake after por", wake, 1'b0);
    chk("R1 flag after por", chg_flag, 1'b0);

    // R3 R4 R7 R8 sweep
    for (int e = 0; e < 16; e++)
      for (int d = 0; d < 16; d++)
        for (int t = 0; t < 16; t++) begin
          logic [7:0] base, dd, tp;
          logic g;
          base = 8'h5A ^ 8'(t * 3);
          dd = {4'(d), 4'(e ^ t)};
          g = 1'(d ^ t);
          tp = base ^ {4'(t), 4'h0};
          step("R8 load", base, dd, 4'(e), g, 1, 0, 1, 1, 1);
          step("R3R4 diff", tp, dd, 4'(e), g, 0, 0, 0, 1, 1);
          step("R7 clr blocked", tp, dd, 4'(e), g, 0, 0, 1, 1, 1);
          step("R8 acc+clr", tp, dd, 4'(e), g, 0, 1, 1, 1, 1);
          step("R8 after", tp, dd, 4'(e), g, 0, 0, 0, 1, 1);
          chk("R8 flag cleared", chg_flag, 1'b0);
        end

    // R2
    step("R2 load", 8'h30, 8'hFF, 4'hF, 1, 1, 0, 1, 1, 1);
    for (int l = 0; l < 256; l++) begin
      step("R2", {4'h3, 4'(l)}, 8'(l ^ 8'hF0), 4'hF, 1, 0, 0, 0, 1, 1);
      chk("R2 wake", wake, 1'b0);
    end

    // R6 sticky after revert
    step("R6 set", 8'hB0, 8'hFF, 4'hF, 1, 0, 0, 0, 1, 1);
    step("R6 revert", 8'h30, 8'hFF, 4'hF, 1, 0, 0, 0, 1, 1);
    chk("R6 sticky", chg_flag, 1'b1);
    step("R6 clr", 8'h30, 8'hFF, 4'hF, 1, 0, 0, 1, 1, 1);
    chk("R6 cleared", chg_flag, 1'b0);

    // R10
    step("R10 diff", 8'h70, 8'hFF, 4'hF, 1, 0, 0, 0, 1, 1);
    step("R10 rst", 8'h70, 8'hFF, 4'hF, 1, 0, 0, 0, 1, 0);
    chk("R10 flag in reset", chg_flag, 1'b0);
    step("R10 rst", 8'h70, 8'hFF, 4'hF, 1, 0, 0, 0, 1, 0);
    step("R10 release", 8'h70, 8'hFF, 4'hF, 1, 0, 0, 0, 1, 1);
    chk("R10 flag returns", chg_flag, 1'b1);
    chk("R10 wake kept", wake, 1'b1);
    step("R10 rst no diff", 8'h30, 8'hFF, 4'hF, 0, 0, 0, 0, 1, 0);
    step("R10 idle", 8'h30, 8'hFF, 4'hF, 0, 0, 0, 0, 1, 1);
    chk("R10 no diff", chg_flag, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule